// File: doc/BRIEF.md
# Symmetric Up/Down PWM Timer

This block is an 8-bit timer that counts up from zero to its top value and then back down. It drives one compare output whose pulse stays centred on the bottom of the count. A prescaler turns the system clock into a single-cycle count enable. The enable can be set to one of seven division ratios, or switched off so that the count holds. One full period covers 510 enable ticks.

The host writes a compare value into a holding register. The timer copies that value into the working compare only at the top of the count, so the duty cycle never changes partway through a period. On the way up, a match drives the output low. On the way down, a match drives it high. At the bottom of the count the output is forced to the level the downward match would have left. A compare of zero therefore gives a steady low output, and a compare at the top value gives a steady high output. A polarity input inverts the whole waveform.

Two sticky flags record events for the host: one for reaching the bottom of the count and one for a compare match. Each flag is cleared by a write-one strobe.

Top module: `pcpwm_timer`

## Requirements
- R1: `presc_sel` sets the count enable rate. Code 0 stops the count. Codes 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 and 1024 clocks. The count changes only on a tick, so with code 2 each count value is held for 8 clocks.
- R2: Starting at 0, the count rises by one per tick up to 255 and then falls by one per tick to 0. It turns around at both ends and holds each end value for one tick only.
- R3: A value strobed in with `cmp_wr` goes into a holding register. It becomes the working compare on the tick at which the count is 255, and that tick's comparison already uses it. Until then the previous value controls the output.
- R4: In non-inverted form, the output level is updated on ticks. A match on a tick where the count is heading up (count 0 included) drives it low. A match heading down (count 255 included) drives it high. At count 0 with a nonzero compare it is driven high even if no match occurred. The output changes one clock after the tick.
- R5: A working compare of 0 keeps the non-inverted output low for the whole period. A working compare of 255 keeps it high.
- R6: With `invert` high, `wave_out` is the complement of the non-inverted level in every case. It follows `invert` without waiting for a clock.
- R7: `ovf_flag` is set on the tick where the count steps from 1 down to 0. It stays set until `flag_clr[0]` is high. A set and a clear in the same cycle leave it set.
- R8: `cmp_flag` is set on every tick where a match occurs. It stays set until `flag_clr[1]` is high. A set and a clear in the same cycle leave it set.
- R9: A clock edge with `rst_n` low does the following: clears the count, the prescaler, both flags, the holding compare, the working compare and the output level; sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_sel | input | 3 | Count enable rate code (0 = stopped) |
| cmp_wr | input | 1 | Strobe that loads `cmp_wdata` into the holding compare |
| cmp_wdata | input | 8 | New compare value |
| invert | input | 1 | 1 = inverted output |
| flag_clr | input | 2 | Write-one clear: bit 0 overflow, bit 1 compare |
| wave_out | output | 1 | PWM output |
| count_out | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky bottom-reached flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The properties assume that `rst_n` is held low for at least one edge before any check matters. They also assume that `flag_clr` is the only thing that lowers a flag. The output-level properties assume the working compare is read at the same tick the counter reaches an end. The stimulus does not strobe `cmp_wr` on the tick at the top of the count, so the bench does not rely on how a same-cycle write and load are ordered. It changes `presc_sel` only between measured intervals. A behavioural model follows every clock and covers all orderings the stimulus creates.

// File: rtl/pcpwm_pkg.sv
// Package: shared types and the divider lookup for the PWM timer.
// Assumes the prescaler counter is at least 10 bits wide to reach 1023.
package pcpwm_pkg;

    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_DIV1    = 3'd1,
        PS_DIV8    = 3'd2,
        PS_DIV32   = 3'd3,
        PS_DIV64   = 3'd4,
        PS_DIV128  = 3'd5,
        PS_DIV256  = 3'd6,
        PS_DIV1024 = 3'd7
    } presc_sel_e;

    // Returns the terminal prescaler count (division ratio minus one).
    function automatic int unsigned presc_limit(presc_sel_e s);
        case (s)
            PS_DIV1:    return 0;
            PS_DIV8:    return 7;
            PS_DIV32:   return 31;
            PS_DIV64:   return 63;
            PS_DIV128:  return 127;
            PS_DIV256:  return 255;
            PS_DIV1024: return 1023;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
// Module: pcpwm_prescaler
// Emits a one-clock tick once every N clocks, with N picked by sel.
// sel of zero stops the tick and holds the counter at zero.
// Assumes PRE_W is wide enough for the largest limit (10 bits).
module pcpwm_prescaler
    import pcpwm_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = PRE_W'(presc_limit(presc_sel_e'(sel)));
    // The >= compare also ends a count left above a newly lowered limit.
    assign tick  = (sel != 3'd0) && (pre_q >= limit);

    // Purpose: free-running divide counter, restarted on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (sel == 3'd0 || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/pcpwm_counter.sv
// Module: pcpwm_counter
// Up/down counter that turns around at zero and at all-ones.
// heading_up gives the direction of the next step from the present count.
// Assumes tick is a single-cycle enable.
module pcpwm_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             heading_up
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic dir_up_q;

    // Purpose: work out the next step direction, reversing at either end.
    always_comb begin
        if (count == '0)
            heading_up = 1'b1;
        else if (count == TOP)
            heading_up = 1'b0;
        else
            heading_up = dir_up_q;
    end

    // Purpose: step the count and remember the direction on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            dir_up_q <= 1'b1;
        end else if (tick) begin
            dir_up_q <= heading_up;
            count    <= heading_up ? count + 1'b1 : count - 1'b1;
        end
    end

endmodule

// File: rtl/pcpwm_wavegen.sv
// Module: pcpwm_wavegen
// Holds the compare value (written by the host, loaded at the top of the
// count), drives the non-inverted output level, and keeps the sticky flags.
// Assumes count and heading_up come from pcpwm_counter, and that tick
// is the same enable that moves the count.
module pcpwm_wavegen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             heading_up,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [1:0]       flag_clr,
    output logic             level,
    output logic [CNT_W-1:0] ocr_act,
    output logic             ovf_flag,
    output logic             cmp_flag
);

    localparam logic [CNT_W-1:0] TOP  = '1;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] ocr_buf;
    logic [CNT_W-1:0] ocr_eff;
    logic             at_top;
    logic             match;
    logic             hit_bottom;

    assign at_top     = (count == TOP);
    assign ocr_eff    = at_top ? ocr_buf : ocr_act;
    assign match      = tick && (count == ocr_eff);
    assign hit_bottom = tick && !heading_up && (count == ONE);

    // Purpose: holding register written by the host at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ocr_buf <= '0;
        else if (cmp_wr)
            ocr_buf <= cmp_wdata;
    end

    // Purpose: working compare, loaded only on the tick at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ocr_act <= '0;
        else if (tick && at_top)
            ocr_act <= ocr_buf;
    end

    // Purpose: output level: low on an upward match, high on a downward one, fixed at bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= 1'b0;
        else if (tick) begin
            if (count == '0)
                level <= (ocr_eff != '0);
            else if (count == ocr_eff)
                level <= !heading_up;
        end
    end

    // Purpose: sticky bottom-reached flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (hit_bottom)
            ovf_flag <= 1'b1;
        else if (flag_clr[0])
            ovf_flag <= 1'b0;
    end

    // Purpose: sticky compare-match flag; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_flag <= 1'b0;
        else if (match)
            cmp_flag <= 1'b1;
        else if (flag_clr[1])
            cmp_flag <= 1'b0;
    end

endmodule

// File: rtl/pcpwm_timer.sv
// Module: pcpwm_timer (top)
// Phase-correct PWM timer: prescaler, up/down counter and waveform generator.
// The polarity select is applied last, so it acts without waiting for a clock.
// Assumes one clock domain and a synchronous active-low reset.
module pcpwm_timer #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       presc_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             invert,
    input  logic [1:0]       flag_clr,
    output logic             wave_out,
    output logic [CNT_W-1:0] count_out,
    output logic             ovf_flag,
    output logic             cmp_flag
);

    logic             tick;
    logic [CNT_W-1:0] count;
    logic             heading_up;
    logic             level;
    logic [CNT_W-1:0] ocr_act;

    pcpwm_prescaler #(.PRE_W(PRE_W)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_sel),
        .tick  (tick)
    );

    pcpwm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .count      (count),
        .heading_up (heading_up)
    );

    pcpwm_wavegen #(.CNT_W(CNT_W)) wave_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .count      (count),
        .heading_up (heading_up),
        .cmp_wr     (cmp_wr),
        .cmp_wdata  (cmp_wdata),
        .flag_clr   (flag_clr),
        .level      (level),
        .ocr_act    (ocr_act),
        .ovf_flag   (ovf_flag),
        .cmp_flag   (cmp_flag)
    );

    assign count_out = count;
    assign wave_out  = level ^ invert;

endmodule

// File: rtl/pcpwm_timer_chk.sv
// Module: pcpwm_timer_chk
// Timing properties for pcpwm_timer, attached with the bind below.
// Assumes it sees the top's internal tick, count, working compare and level.
module pcpwm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] ocr_act,
    input logic             level,
    input logic             ovf_flag,
    input logic             cmp_flag,
    input logic [1:0]       flag_clr
);

    localparam logic [CNT_W-1:0] TOP = '1;

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    p_top_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == TOP) |=> (count == TOP - 1'b1));

    p_bottom_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0) |=> (count == CNT_W'(1)));

    p_ocr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && count == TOP) |=> $stable(ocr_act));

    p_bottom_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0 && ocr_act != '0) |=> level);

    p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == '0 && ocr_act == '0) |=> !level);

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr[0]) |=> ovf_flag);

    p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr[1]) |=> cmp_flag);

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !ovf_flag && !cmp_flag && !level && ocr_act == '0));

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .count    (count),
    .ocr_act  (ocr_act),
    .level    (level),
    .ovf_flag (ovf_flag),
    .cmp_flag (cmp_flag),
    .flag_clr (flag_clr)
);

// File: tb/pcpwm_timer_tb_top.sv
module pcpwm_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;

    logic         clk       = 1'b0;
    logic         rst_n     = 1'b0;
    logic [2:0]   presc_sel = 3'd0;
    logic         cmp_wr    = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         invert    = 1'b0;
    logic [1:0]   flag_clr  = 2'b00;
    logic         wave_out;
    logic [W-1:0] count_out;
    logic         ovf_flag;
    logic         cmp_flag;

    int n_checks = 0;
    int n_errors = 0;
    bit started  = 0;
    bit finished = 0;

    pcpwm_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_sel (presc_sel),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .invert    (invert),
        .flag_clr  (flag_clr),
        .wave_out  (wave_out),
        .count_out (count_out),
        .ovf_flag  (ovf_flag),
        .cmp_flag  (cmp_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_pre = 0, m_cnt = 0, m_buf = 0, m_act = 0;
    bit m_up = 1, m_lvl = 0, m_ovf = 0, m_cmp = 0;
    int d_ratio, m_eff;
    bit m_tick, set_ovf, set_cmp;

    function automatic int ratio_of(input int code);
        case (code)
            1: return 1;    2: return 8;    3: return 32;  4: return 64;
            5: return 128;  6: return 256;  7: return 1024;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_buf = 0; m_act = 0;
            m_up = 1; m_lvl = 0; m_ovf = 0; m_cmp = 0;
        end else begin
            d_ratio = ratio_of(int'(presc_sel));
            m_tick  = (d_ratio != 0) && (m_pre >= d_ratio - 1);
            if (d_ratio == 0 || m_tick) m_pre = 0; else m_pre = m_pre + 1;
            set_ovf = 0;
            set_cmp = 0;
            if (m_tick) begin
                if (m_up && m_cnt == 255) m_up = 0;
                else if (!m_up && m_cnt == 0) m_up = 1;
                m_eff = (m_cnt == 255) ? m_buf : m_act;
                if (m_cnt == m_eff) set_cmp = 1;
                if (m_cnt == 0) m_lvl = (m_eff != 0);
                else if (m_cnt == m_eff) m_lvl = !m_up;
                if (!m_up && m_cnt == 1) set_ovf = 1;
                if (m_cnt == 255) m_act = m_buf;
                m_cnt = m_up ? m_cnt + 1 : m_cnt - 1;
            end
            if (set_ovf) m_ovf = 1; else if (flag_clr[0]) m_ovf = 0;
            if (set_cmp) m_cmp = 1; else if (flag_clr[1]) m_cmp = 0;
            if (cmp_wr) m_buf = int'(cmp_wdata);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            check(int'(count_out) == m_cnt, "R2 count", int'(count_out), m_cnt);
            check(wave_out == (m_lvl ^ invert), "R4 wave", int'(wave_out), int'(m_lvl ^ invert));
            check(ovf_flag == m_ovf, "R7 ovf_flag", int'(ovf_flag), int'(m_ovf));
            check(cmp_flag == m_cmp, "R8 cmp_flag", int'(cmp_flag), int'(m_cmp));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic write_cmp(input int v);
        cmp_wdata = W'(v);
        cmp_wr    = 1'b1;
        step(1);
        cmp_wr    = 1'b0;
    endtask

    task automatic pulse_clear();
        flag_clr = 2'b11;
        step(1);
        flag_clr = 2'b00;
    endtask

    task automatic wait_count(input int v);
        for (int i = 0; i < 3000 && int'(count_out) != v; i++) step(1);
    endtask

    // Waits for the top, then steps one clock so the new compare is active.
    task automatic pass_top();
        wait_count(255);
        step(1);
    endtask

    task automatic measure_hold(input int expect_n, input string req);
        int prev;
        int n;
        prev = int'(count_out);
        for (int i = 0; i < 3000 && int'(count_out) == prev; i++) step(1);
        prev = int'(count_out);
        n = 0;
        for (int i = 0; i < 3000 && int'(count_out) == prev; i++) begin
            step(1);
            n++;
        end
        check(n == expect_n, req, n, expect_n);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        bit w0;
        bit steady;
        step(5);
        // R9: reset state seen at the ports
        check(count_out == '0, "R9 count after reset", int'(count_out), 0);
        check(!ovf_flag && !cmp_flag, "R9 flags after reset", int'({ovf_flag, cmp_flag}), 0);
        check(wave_out == 1'b0, "R9 wave after reset", int'(wave_out), 0);
        rst_n = 1'b1;

        // Divide by 1, compare 100, two periods with flag clears in between
        presc_sel = 3'd1;
        write_cmp(100);
        step(600);
        pulse_clear();
        step(500);
        pulse_clear();

        // R3: new value must wait for the top before it governs the output
        write_cmp(200);
        pass_top();
        wait_count(0);
        wait_count(10);
        write_cmp(50);
        wait_count(120);
        check(wave_out == 1'b1, "R3 old compare still active", int'(wave_out), 1);
        step(300);

        // R5: compare 0 gives a steady low output over a whole period
        write_cmp(0);
        pass_top();
        steady = 1;
        for (int i = 0; i < 520; i++) begin
            step(1);
            if (wave_out != 1'b0) steady = 0;
        end
        check(steady, "R5 compare 0 steady low", int'(steady), 1);

        // R5: compare 255 gives a steady high output
        write_cmp(255);
        pass_top();
        steady = 1;
        for (int i = 0; i < 520; i++) begin
            step(1);
            if (wave_out != 1'b1) steady = 0;
        end
        check(steady, "R5 compare 255 steady high", int'(steady), 1);

        // R6: inversion acts without a clock edge
        write_cmp(60);
        pass_top();
        wait_count(30);
        w0 = wave_out;
        invert = 1'b1;
        #1;
        check(wave_out == !w0, "R6 invert immediate", int'(wave_out), int'(!w0));
        step(600);
        pulse_clear();
        step(200);

        // R1: prescale rates and the stopped setting
        presc_sel = 3'd2;
        measure_hold(8, "R1 divide by 8");
        step(40);
        presc_sel = 3'd3;
        measure_hold(32, "R1 divide by 32");
        presc_sel = 3'd7;
        measure_hold(1024, "R1 divide by 1024");
        presc_sel = 3'd0;
        w0 = 0;
        begin
            int held;
            held = int'(count_out);
            step(100);
            check(int'(count_out) == held, "R1 stopped holds count", int'(count_out), held);
        end

        // R9: reset in mid-run
        presc_sel = 3'd1;
        step(77);
        invert = 1'b0;
        rst_n  = 1'b0;
        step(1);
        check(count_out == '0, "R9 count after mid-run reset", int'(count_out), 0);
        check(!ovf_flag && !cmp_flag, "R9 flags after mid-run reset", int'({ovf_flag, cmp_flag}), 0);
        check(wave_out == 1'b0, "R9 wave after mid-run reset", int'(wave_out), 0);
        rst_n = 1'b1;
        step(300);

        finish_run();
    end

endmodule